// File: doc/BRIEF.md
# Packet Buffer Page Queue Manager

This block keeps track of which pages of an on-board packet memory are free, waiting to be transmitted, holding received frames, or reporting transmit completion. Four first-in first-out queues of page numbers share one pool of pages. A host reaches them through a byte-wide register port: reading a queue's data register pops that queue, writing it pushes, and every queue has a count register that can be read freely. Simple strobes stand in for the MAC side. A frame arrival takes a page from the free queue and places it on the receive queue. A transmit take removes the head of the transmit queue. A done strobe pushes a status value onto the transmit-done queue.

Page 0 is never a valid buffer. It is returned whenever the host pops an empty queue, so the host can recognise that no space is left. The free queue is filled in ascending order, with pages 1 up to a last page of 63 or 127, at reset and again on every configuration write. The configuration write picks the memory size. When a frame arrives and no free page is left, the block sets its receive-disable flag and drops the frame. The host re-enables reception by writing that flag back to 0.

Register map (4-bit address): 0 status, 1 configuration, 2 free data, 3 free count, 4 transmit data, 5 transmit count, 6 receive data, 7 receive count, 8 done data, 9 done count. Addresses without a register read as 0. Status bits: bit 0 receive queue not empty, bit 1 done queue not empty, bit 2 transmit disabled, bit 3 receive disabled, bit 4 sticky overflow.

Top module: `pbuf_page_qmgr`

## Requirements
- R1: After reset the free count reads 63, every other count reads 0 and status reads 0x00. Successive free-data reads return 1, 2, 3 and the free count drops by one per read.
- R2: A write to the configuration register with bit 0 = 1 empties the transmit, receive and done queues. It refills the free queue with pages 1..127 in ascending order (count 127) and configuration reads back 1. With bit 0 = 0 the refill is pages 1..63.
- R3: A data read of an empty queue returns 0 and leaves its count at 0.
- R4: Host writes to transmit data push bits [6:0] in order. While the transmit queue is non-empty and transmit is enabled, tx_avail is 1 and tx_page shows the head. A tx_take pulse pops it.
- R5: A rx_frame pulse with reception enabled and a free page available asserts rx_grant in that cycle, with rx_page equal to the free-queue head. That page moves to the receive queue and status bit 0 becomes 1. Receive-data reads return the pages in arrival order.
- R6: A rx_frame pulse while the free queue is empty sets status bit 3 and drops the frame: rx_grant stays 0 and the receive count is unchanged. While bit 3 is set, frames are dropped even when free pages exist. This set takes priority over a status write in the same cycle.
- R7: A status write loads bits 2 and 3 into the transmit-disable and receive-disable flags, so writing 0 re-enables a direction. While bit 2 is set, tx_avail is 0 and tx_take leaves the transmit count unchanged.
- R8: done_push places done_status on the done queue. Status bit 1 shows it is non-empty, and done-data reads return the entries in push order.
- R9: A push to a queue holding 128 entries is ignored and sets status bit 4. Bit 4 stays set until a configuration write.
- R10: Reading any count register changes no queue.
- R11: When rx_frame and a host free-data read fall in the same cycle, the frame gets the page. The host read returns 0 and pops nothing.
- R12: A host write to free data pushes a page back, raising the free count by one. The page leaves the queue after the pages already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops data registers) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address and state |
| rx_frame | input | 1 | A frame is arriving and needs a page |
| rx_grant | output | 1 | The arriving frame got a page this cycle |
| rx_page | output | 7 | Page given to the frame, valid with rx_grant |
| tx_avail | output | 1 | A page is queued and transmit is enabled |
| tx_page | output | 7 | Head of the transmit queue |
| tx_take | input | 1 | MAC takes the transmit-queue head |
| done_push | input | 1 | Push a completion status |
| done_status | input | 7 | Completion status value |

## Verification
Most internal faults show up as a wrong page number in the first pop that follows. A broken pointer, a wrong preload value or a lost push all show in the next data read or the next rx_page. Wrong count logic appears in the count register immediately. A flag error shows in the same cycle as a wrong rx_grant or tx_avail, or in the status register on the next read. Full-drain sequences over both memory sizes catch faults that only appear at the last page or when the pointers wrap.

// File: rtl/pq_pkg.sv
// Shared register addresses and status bit positions of the page queue manager.
package pq_pkg;
    typedef enum logic [3:0] {
        RA_STATUS    = 4'd0,
        RA_CONFIG    = 4'd1,
        RA_FREE_DATA = 4'd2,
        RA_FREE_CNT  = 4'd3,
        RA_TX_DATA   = 4'd4,
        RA_TX_CNT    = 4'd5,
        RA_RX_DATA   = 4'd6,
        RA_RX_CNT    = 4'd7,
        RA_DONE_DATA = 4'd8,
        RA_DONE_CNT  = 4'd9
    } reg_addr_e;

    localparam int unsigned ST_RXNE   = 0;
    localparam int unsigned ST_DONENE = 1;
    localparam int unsigned ST_TXOFF  = 2;
    localparam int unsigned ST_RXOFF  = 3;
    localparam int unsigned ST_OVF    = 4;
    localparam int unsigned HOST_W    = 8;
endpackage

// File: rtl/page_fifo.sv
// Page-number FIFO with single-cycle push and pop.
// Assumes DEPTH is a power of two. A push when full and a pop when empty
// are ignored. With PRELOAD set, reset or load fills entries with 1,2,3,...
// and sets the count to load_count; otherwise load empties the queue.
module page_fifo #(
    parameter int unsigned W       = 7,
    parameter int unsigned DEPTH   = 128,
    parameter bit          PRELOAD = 1'b0,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_count,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          full, start, do_push, do_pop;

    assign start    = !rst_n || load;
    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head     = mem[rd_ptr];
    assign overflow = push && full && !start;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (start) begin
            rd_ptr <= '0;
            wr_ptr <= PRELOAD ? load_count[AW-1:0] : '0;
            count  <= PRELOAD ? load_count : '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    generate
        if (PRELOAD) begin : g_preload
            // Storage write: ascending page fill on start, else one push.
            always_ff @(posedge clk) begin
                if (start) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= W'(i + 1);
                end else if (do_push) begin
                    mem[wr_ptr] <= push_data;
                end
            end
        end else begin : g_plain
            // Storage write: one push per cycle.
            always_ff @(posedge clk) begin
                if (do_push && !start) mem[wr_ptr] <= push_data;
            end
        end
    endgenerate

    assert_full_push_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !load) |=> (count == $past(count)));

    assert_empty_pop_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !load) |=> empty);
endmodule

// File: rtl/pq_flow_ctrl.sv
// Direction enables, memory size and sticky overflow flag.
// Assumes one-cycle strobes. Frame admission requires reception enabled and a
// free page. A dry-pool arrival sets receive-disable ahead of a status write.
module pq_flow_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_status,
    input  logic wr_config,
    input  logic bit_txoff,
    input  logic bit_rxoff,
    input  logic bit_big,
    input  logic rx_frame,
    input  logic free_empty,
    input  logic tx_take,
    input  logic tx_empty,
    input  logic any_overflow,
    output logic tx_dis,
    output logic rx_dis,
    output logic ovf,
    output logic mem_big,
    output logic rx_grant,
    output logic tx_fire
);
    logic dry_hit;

    assign dry_hit  = rx_frame && !rx_dis && free_empty;
    assign rx_grant = rx_frame && !rx_dis && !free_empty;
    assign tx_fire  = tx_take && !tx_dis && !tx_empty;

    // Receive-disable: set by a dry arrival, otherwise loaded by status writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_dis <= 1'b0;
        else if (dry_hit)   rx_dis <= 1'b1;
        else if (wr_status) rx_dis <= bit_rxoff;
    end

    // Transmit-disable: loaded by status writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_dis <= 1'b0;
        else if (wr_status) tx_dis <= bit_txoff;
    end

    // Sticky overflow, cleared by configuration writes; memory size select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf     <= 1'b0;
            mem_big <= 1'b0;
        end else if (wr_config) begin
            ovf     <= 1'b0;
            mem_big <= bit_big;
        end else if (any_overflow) begin
            ovf     <= 1'b1;
        end
    end

    assert_dry_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame && free_empty && !rx_dis) |=> rx_dis);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_config) |=> ovf);
endmodule

// File: rtl/pq_host_port.sv
// Byte-wide register decode: turns host strobes into queue pushes and pops and
// selects read data. Assumes read data is taken in the strobe cycle. Data
// reads of empty queues, or of the free queue while the MAC takes its head,
// return 0 and pop nothing.
module pq_host_port #(
    parameter int unsigned PAGE_W = 7,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [3:0]        addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        status,
    input  logic              mem_big,
    input  logic              mac_takes_free,
    input  logic [PAGE_W-1:0] free_head,
    input  logic              free_empty,
    input  logic [CNT_W-1:0]  free_cnt,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [PAGE_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [PAGE_W-1:0] done_head,
    input  logic              done_empty,
    input  logic [CNT_W-1:0]  done_cnt,
    output logic              wr_status,
    output logic              wr_config,
    output logic              push_free,
    output logic              push_tx,
    output logic              pop_free,
    output logic              pop_rx,
    output logic              pop_done,
    output logic [PAGE_W-1:0] push_page,
    output logic [7:0]        rdata
);
    import pq_pkg::*;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[7:PAGE_W];
    assign push_page       = wdata[PAGE_W-1:0];

    // Write and pop strobe decode.
    always_comb begin
        wr_status = wr && (addr == RA_STATUS);
        wr_config = wr && (addr == RA_CONFIG);
        push_free = wr && (addr == RA_FREE_DATA);
        push_tx   = wr && (addr == RA_TX_DATA);
        pop_free  = rd && (addr == RA_FREE_DATA) && !mac_takes_free;
        pop_rx    = rd && (addr == RA_RX_DATA);
        pop_done  = rd && (addr == RA_DONE_DATA);
    end

    // Read data select.
    always_comb begin
        case (addr)
            RA_STATUS:    rdata = status;
            RA_CONFIG:    rdata = 8'(mem_big);
            RA_FREE_DATA: rdata = (free_empty || mac_takes_free) ? 8'h00 : 8'(free_head);
            RA_FREE_CNT:  rdata = 8'(free_cnt);
            RA_TX_CNT:    rdata = 8'(tx_cnt);
            RA_RX_DATA:   rdata = rx_empty ? 8'h00 : 8'(rx_head);
            RA_RX_CNT:    rdata = 8'(rx_cnt);
            RA_DONE_DATA: rdata = done_empty ? 8'h00 : 8'(done_head);
            RA_DONE_CNT:  rdata = 8'(done_cnt);
            default:      rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pbuf_page_qmgr.sv
// Packet buffer page queue manager: four page-number FIFOs (free, transmit,
// receive, transmit-done) sharing one page pool, a host register port and
// MAC-side strobes. Assumes a host that keeps pages unique; duplicates are
// stored as given. All operations complete in one clock.
module pbuf_page_qmgr #(
    parameter int unsigned PAGE_W = 7,
    localparam int unsigned DEPTH      = 2 ** PAGE_W,
    localparam int unsigned CNT_W      = PAGE_W + 1,
    localparam int unsigned LAST_BIG   = DEPTH - 1,
    localparam int unsigned LAST_SMALL = DEPTH / 2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              rx_frame,
    output logic              rx_grant,
    output logic [PAGE_W-1:0] rx_page,
    output logic              tx_avail,
    output logic [PAGE_W-1:0] tx_page,
    input  logic              tx_take,
    input  logic              done_push,
    input  logic [PAGE_W-1:0] done_status
);
    import pq_pkg::*;

    logic              wr_status, wr_config, push_free, push_tx;
    logic              pop_free, pop_rx, pop_done, tx_fire;
    logic [PAGE_W-1:0] push_page, free_head, tx_head, rx_head, done_head;
    logic [CNT_W-1:0]  free_cnt, tx_cnt, rx_cnt, done_cnt, free_load_cnt;
    logic              free_empty, tx_empty, rx_empty, done_empty;
    logic              free_ovf, tx_ovf, rx_ovf, done_ovf;
    logic              tx_dis, rx_dis, ovf, mem_big;
    logic [7:0]        status;

    assign free_load_cnt = (rst_n && wr_config && host_wdata[0]) ?
                           CNT_W'(LAST_BIG) : CNT_W'(LAST_SMALL);
    assign rx_page  = free_head;
    assign tx_page  = tx_head;
    assign tx_avail = !tx_empty && !tx_dis;

    // Status byte assembly.
    always_comb begin
        status            = 8'h00;
        status[ST_RXNE]   = !rx_empty;
        status[ST_DONENE] = !done_empty;
        status[ST_TXOFF]  = tx_dis;
        status[ST_RXOFF]  = rx_dis;
        status[ST_OVF]    = ovf;
    end

    pq_host_port #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_port (
        .wr(host_wr), .rd(host_rd), .addr(host_addr), .wdata(host_wdata),
        .status(status), .mem_big(mem_big), .mac_takes_free(rx_grant),
        .free_head(free_head), .free_empty(free_empty), .free_cnt(free_cnt),
        .tx_cnt(tx_cnt),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_cnt(rx_cnt),
        .done_head(done_head), .done_empty(done_empty), .done_cnt(done_cnt),
        .wr_status(wr_status), .wr_config(wr_config), .push_free(push_free),
        .push_tx(push_tx), .pop_free(pop_free), .pop_rx(pop_rx),
        .pop_done(pop_done), .push_page(push_page), .rdata(host_rdata)
    );

    pq_flow_ctrl u_flow (
        .clk(clk), .rst_n(rst_n), .wr_status(wr_status), .wr_config(wr_config),
        .bit_txoff(host_wdata[ST_TXOFF]), .bit_rxoff(host_wdata[ST_RXOFF]),
        .bit_big(host_wdata[0]), .rx_frame(rx_frame), .free_empty(free_empty),
        .tx_take(tx_take), .tx_empty(tx_empty),
        .any_overflow(free_ovf || tx_ovf || rx_ovf || done_ovf),
        .tx_dis(tx_dis), .rx_dis(rx_dis), .ovf(ovf), .mem_big(mem_big),
        .rx_grant(rx_grant), .tx_fire(tx_fire)
    );

    page_fifo #(.W(PAGE_W), .DEPTH(DEPTH), .PRELOAD(1'b1)) u_free_q (
        .clk(clk), .rst_n(rst_n), .load(wr_config), .load_count(free_load_cnt),
        .push(push_free), .push_data(push_page), .pop(rx_grant || pop_free),
        .head(free_head), .count(free_cnt), .empty(free_empty), .overflow(free_ovf)
    );

    page_fifo #(.W(PAGE_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .load(wr_config), .load_count(free_load_cnt),
        .push(push_tx), .push_data(push_page), .pop(tx_fire),
        .head(tx_head), .count(tx_cnt), .empty(tx_empty), .overflow(tx_ovf)
    );

    page_fifo #(.W(PAGE_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .load(wr_config), .load_count(free_load_cnt),
        .push(rx_grant), .push_data(free_head), .pop(pop_rx),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .overflow(rx_ovf)
    );

    page_fifo #(.W(PAGE_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_done_q (
        .clk(clk), .rst_n(rst_n), .load(wr_config), .load_count(free_load_cnt),
        .push(done_push), .push_data(done_status), .pop(pop_done),
        .head(done_head), .count(done_cnt), .empty(done_empty), .overflow(done_ovf)
    );

    assert_grant_moves_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_grant && !pop_rx && !wr_config && (rx_cnt != CNT_W'(DEPTH)))
        |=> (rx_cnt == $past(rx_cnt) + 1'b1));

    assert_txoff_blocks_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && tx_dis && !push_tx && !wr_config) |=> (tx_cnt == $past(tx_cnt)));

    assert_dry_drops_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame && free_empty) |-> !rx_grant);
endmodule

// File: tb/pbuf_page_qmgr_bench.sv
// Scoreboard bench: drivers queue the expected read data, and a monitor
// compares each host read at the falling edge.
module pbuf_page_qmgr_bench;
    import pq_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       rx_frame = 1'b0, rx_grant, tx_avail, tx_take = 1'b0, done_push = 1'b0;
    logic [6:0] rx_page, tx_page, done_status = '0;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    pbuf_page_qmgr u_pbuf_page_qmgr (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_frame(rx_frame), .rx_grant(rx_grant), .rx_page(rx_page),
        .tx_avail(tx_avail), .tx_page(tx_page), .tx_take(tx_take),
        .done_push(done_push), .done_status(done_status)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: compare each host read against the scoreboard head.
    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) chk("scoreboard underrun", 1, 0);
            else chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hread(logic [3:0] a, logic [7:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        host_addr = a;
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
    endtask

    task automatic hwrite(logic [3:0] a, logic [7:0] d);
        host_addr = a;
        host_wdata = d;
        host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rx_pulse(logic eg, logic [6:0] ep, string tag);
        rx_frame = 1'b1;
        @(negedge clk);
        chk({tag, " rx_grant"}, rx_grant, eg);
        if (eg) chk({tag, " rx_page"}, rx_page, ep);
        tick();
        rx_frame = 1'b0;
    endtask

    task automatic tx_look(logic ea, logic [6:0] ep, string tag);
        @(negedge clk);
        chk({tag, " tx_avail"}, tx_avail, ea);
        if (ea) chk({tag, " tx_page"}, tx_page, ep);
        tick();
    endtask

    task automatic tx_pulse();
        tx_take = 1'b1;
        tick();
        tx_take = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state and ascending free pops
        hread(RA_FREE_CNT, 8'd63, "R1 free count");
        hread(RA_STATUS, 8'h00, "R1 status");
        hread(RA_TX_CNT, 8'd0, "R1 tx count");
        hread(RA_RX_CNT, 8'd0, "R1 rx count");
        hread(RA_DONE_CNT, 8'd0, "R1 done count");
        hread(RA_FREE_DATA, 8'd1, "R1 pop 1");
        hread(RA_FREE_DATA, 8'd2, "R1 pop 2");
        hread(RA_FREE_DATA, 8'd3, "R1 pop 3");
        hread(RA_FREE_CNT, 8'd60, "R1 count after pops");

        // R12: return a page
        hwrite(RA_FREE_DATA, 8'd2);
        hread(RA_FREE_CNT, 8'd61, "R12 count after return");

        // R4: transmit queue order
        hwrite(RA_TX_DATA, 8'd10);
        hwrite(RA_TX_DATA, 8'd20);
        hwrite(RA_TX_DATA, 8'd30);
        hread(RA_TX_CNT, 8'd3, "R4 tx count");
        tx_look(1'b1, 7'd10, "R4 head");
        tx_pulse();
        tx_look(1'b1, 7'd20, "R4 next head");

        // R7: transmit disable and re-enable
        hwrite(RA_STATUS, 8'h04);
        tx_look(1'b0, 7'd0, "R7 disabled");
        tx_pulse();
        hread(RA_TX_CNT, 8'd2, "R7 count held");
        hread(RA_STATUS, 8'h04, "R7 status");
        hwrite(RA_STATUS, 8'h00);
        tx_look(1'b1, 7'd20, "R7 re-enabled");

        // R5: frame arrival takes free head
        rx_pulse(1'b1, 7'd4, "R5 arrival");
        hread(RA_RX_CNT, 8'd1, "R5 rx count");
        hread(RA_STATUS, 8'h01, "R5 status");
        hread(RA_FREE_CNT, 8'd60, "R5 free count");
        hread(RA_RX_DATA, 8'd4, "R5 rx data");

        // R8: done queue
        done_status = 7'h55; done_push = 1'b1; tick();
        done_status = 7'h2A; tick();
        done_push = 1'b0;
        hread(RA_STATUS, 8'h02, "R8 status");
        hread(RA_DONE_CNT, 8'd2, "R8 count");
        hread(RA_DONE_DATA, 8'h55, "R8 first");
        hread(RA_DONE_DATA, 8'h2A, "R8 second");
        hread(RA_DONE_CNT, 8'd0, "R8 drained");

        // R11: same-cycle arrival and host free pop
        exp_q.push_back(8'd0);
        tag_q.push_back("R11 host read");
        host_addr = RA_FREE_DATA;
        host_rd = 1'b1;
        rx_frame = 1'b1;
        @(negedge clk);
        chk("R11 rx_grant", rx_grant, 1);
        chk("R11 rx_page", rx_page, 5);
        tick();
        host_rd = 1'b0;
        rx_frame = 1'b0;
        hread(RA_FREE_CNT, 8'd59, "R11 free count");
        hread(RA_RX_DATA, 8'd5, "R11 rx data");

        // R3: drain free queue, then empty pop
        for (int i = 6; i <= 63; i++) hread(RA_FREE_DATA, 8'(i), "R3 drain");
        hread(RA_FREE_DATA, 8'd2, "R12 returned page last");
        hread(RA_FREE_DATA, 8'd0, "R3 empty pop");
        hread(RA_FREE_CNT, 8'd0, "R3 count stays 0");

        // R6: dry pool disables reception
        rx_pulse(1'b0, 7'd0, "R6 dry arrival");
        hread(RA_STATUS, 8'h08, "R6 status");
        hread(RA_RX_CNT, 8'd0, "R6 rx count");
        hwrite(RA_FREE_DATA, 8'd7);
        rx_pulse(1'b0, 7'd0, "R6 dropped while disabled");
        hread(RA_FREE_CNT, 8'd1, "R6 free kept");
        hwrite(RA_STATUS, 8'h00);
        rx_pulse(1'b1, 7'd7, "R7 rx re-enabled");
        hread(RA_RX_CNT, 8'd1, "R7 rx count");

        // R10: count reads are side-effect free
        hread(RA_RX_CNT, 8'd1, "R10 repeat read");
        hread(RA_STATUS, 8'h01, "R10 status");

        // R2: big reinit
        hwrite(RA_CONFIG, 8'h01);
        hread(RA_FREE_CNT, 8'd127, "R2 free count");
        hread(RA_TX_CNT, 8'd0, "R2 tx cleared");
        hread(RA_RX_CNT, 8'd0, "R2 rx cleared");
        hread(RA_CONFIG, 8'h01, "R2 config");
        for (int i = 1; i <= 127; i++) hread(RA_FREE_DATA, 8'(i), "R2 ascending");
        hread(RA_FREE_DATA, 8'd0, "R3 empty after big drain");

        // R9: overflow on full queue
        for (int i = 0; i < 128; i++) hwrite(RA_FREE_DATA, 8'((i + 1) % 128));
        hread(RA_STATUS, 8'h00, "R9 no overflow yet");
        hwrite(RA_FREE_DATA, 8'h33);
        hread(RA_STATUS, 8'h10, "R9 overflow flag");
        hread(RA_FREE_CNT, 8'd128, "R9 count held");
        hread(RA_FREE_DATA, 8'd1, "R9 first entry");
        hread(RA_STATUS, 8'h10, "R9 flag sticky");
        hwrite(RA_CONFIG, 8'h00);
        hread(RA_STATUS, 8'h00, "R9 cleared by config");
        hread(RA_FREE_CNT, 8'd63, "R2 small reinit");

        tick();
        summary();
        $finish;
    end
endmodule